// File: doc/BRIEF.md
# Single-Channel PWM Generator with Test Overrides

This block produces one pulse-width-modulated output from a programmable prescaler and an 8-bit channel counter. A down-counting scale counter divides the clock. Each time it reaches zero, the channel counter takes one step. In edge mode the channel counter runs from 0 up to period minus one and then restarts. In center mode it climbs to the period value and falls back to 0. The output is high while the count is below the duty value.

Software programs the block through a simple synchronous register port with a combinational read path. A small test register holds four override bits:

- Keep the count when the counter register is written.
- Ignore period matches.
- Skip the reload of the scale counter when the scale register is written.
- Freeze the clock divider while a debug halt is asserted.

The test register can be written only while the special-mode input is high. It is cleared whenever that input is low.

Top module: `pwm_chan`

Register map (address on `addr_i`):
- 0 control: bit 0 enable, bit 1 center mode.
- 1 scale.
- 2 period.
- 3 duty.
- 4 count: a write clears the counter (the data is not used), and a read returns the live count.
- 5 test: bit 0 keep count on write, bit 1 ignore period match, bit 2 no scale load, bit 3 halt in debug.

Unused addresses read 0.

## Requirements
- R1: After reset every register, including the count, reads 0 and `pwm_o` is low.
- R2: With scale value s, the channel counter advances once every s+1 clocks. With the no-scale-load bit (test bit 2) clear, a scale write loads the scale counter with the written value in the same edge.
- R3: In edge mode (control bit 1 = 0) the count runs 0, 1, ..., period-1, 0. The output is high while count < duty.
- R4: In center mode (control bit 1 = 1) the count runs 0 up to period and back down to 0. A full cycle is 2*period steps, and the output is high while count < duty.
- R5: Duty 0 gives a constant low output. Duty >= period gives a constant high output while the channel is enabled.
- R6: With test bit 0 clear, a write to address 4 sets the count to 0 at that edge.
- R7: With test bit 0 set, a write to address 4 leaves the count stepping as if no write occurred.
- R8: In edge mode with test bit 1 set, reaching the period does not restart the count, which keeps incrementing.
- R9: In center mode with test bit 1 set, reaching the period does not reverse the direction.
- R10: With test bit 2 set, a scale write updates only the scale register. The running scale counter finishes its current countdown and reloads from the previous register value.
- R11: With test bit 3 set and `debug_halt_i` high, the count does not change. With test bit 3 clear, `debug_halt_i` has no effect.
- R12: The test register accepts writes only while `special_mode_i` is high. It reads 0 and its bits are cleared whenever `special_mode_i` is low.
- R13: While control bit 0 is clear, the count is held at 0 and `pwm_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| special_mode_i | input | 1 | Enables writes to the test register |
| debug_halt_i | input | 1 | Device is in debug halt |
| pwm_o | output | 1 | PWM output |

## Verification
The hardest case to reach is the no-scale-load override, because its only visible effect is the timing of a single prescaler reload. The bench sets the scale to 0 so that the scale counter sits at zero every cycle. It then writes a large scale value and reads the count a few cycles later. A normal load gives one extra step, and a suppressed load gives two. The period-ignore and debug-freeze overrides are observed the same way, by reading exact count values a known number of edges after the channel is enabled.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL   = 3'd0,
    ADDR_SCALE  = 3'd1,
    ADDR_PERIOD = 3'd2,
    ADDR_DUTY   = 3'd3,
    ADDR_COUNT  = 3'd4,
    ADDR_TEST   = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic halt_dbg;
    logic no_scale_ld;
    logic ign_period;
    logic keep_cnt;
  } test_bits_t;
endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
  import pwm_chan_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              special_mode_i,
  input  logic [DW-1:0]     cnt_i,
  output logic [DW-1:0]     rdata_o,
  output logic              en_o,
  output logic              center_o,
  output logic [DW-1:0]     scale_o,
  output logic [DW-1:0]     period_o,
  output logic [DW-1:0]     duty_o,
  output test_bits_t        test_o,
  output logic              scale_wr_o,
  output logic              cnt_wr_o
);
  localparam int unsigned TW = $bits(test_bits_t);

  logic [1:0]  ctrl_q;
  logic [DW-1:0] scale_q, period_q, duty_q;
  test_bits_t  test_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      scale_q  <= '0;
      period_q <= '0;
      duty_q   <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        ADDR_CTRL:   ctrl_q   <= wdata_i[1:0];
        ADDR_SCALE:  scale_q  <= wdata_i;
        ADDR_PERIOD: period_q <= wdata_i;
        ADDR_DUTY:   duty_q   <= wdata_i;
        default: ;
      endcase
    end
  end

  // test bits live only in special mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  test_q <= '0;
    else if (!special_mode_i)                     test_q <= '0;
    else if (wr_en_i && addr_i == ADDR_TEST)      test_q <= test_bits_t'(wdata_i[TW-1:0]);
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTRL:   rdata_o = DW'(ctrl_q);
      ADDR_SCALE:  rdata_o = scale_q;
      ADDR_PERIOD: rdata_o = period_q;
      ADDR_DUTY:   rdata_o = duty_q;
      ADDR_COUNT:  rdata_o = cnt_i;
      ADDR_TEST:   rdata_o = DW'(test_q);
      default:     rdata_o = '0;
    endcase
  end

  assign en_o       = ctrl_q[0];
  assign center_o   = ctrl_q[1];
  assign scale_o    = scale_q;
  assign period_o   = period_q;
  assign duty_o     = duty_q;
  assign test_o     = test_q;
  assign scale_wr_o = wr_en_i && (addr_i == ADDR_SCALE) && !test_q.no_scale_ld;
  assign cnt_wr_o   = wr_en_i && (addr_i == ADDR_COUNT);
endmodule

// File: rtl/pwm_chan_scaler.sv
module pwm_chan_scaler #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  input  logic [DW-1:0] scale_i,
  output logic          tick_o
);
  logic [DW-1:0] sc_q;

  assign tick_o = run_i && (sc_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sc_q <= '0;
    else if (load_i)  sc_q <= load_val_i;
    else if (run_i)   sc_q <= (sc_q == '0) ? scale_i : sc_q - DW'(1);
  end
endmodule

// File: rtl/pwm_chan_counter.sv
module pwm_chan_counter #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          center_i,
  input  logic          tick_i,
  input  logic          clr_i,
  input  logic          ign_period_i,
  input  logic [DW-1:0] period_i,
  input  logic [DW-1:0] duty_i,
  output logic [DW-1:0] cnt_o,
  output logic          pwm_o
);
  logic [DW-1:0] cnt_q, cnt_inc;
  logic          up_q;

  assign cnt_inc = cnt_q + DW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (!en_i || clr_i) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (tick_i) begin
      if (!center_i) begin
        up_q  <= 1'b1;
        cnt_q <= (!ign_period_i && cnt_inc == period_i) ? '0 : cnt_inc;
      end else if (up_q) begin
        if (!ign_period_i && cnt_q == period_i) begin
          up_q  <= 1'b0;
          cnt_q <= (cnt_q == '0) ? '0 : cnt_q - DW'(1);
        end else begin
          cnt_q <= cnt_inc;
        end
      end else if (cnt_q == '0) begin
        up_q  <= 1'b1;
        cnt_q <= (period_i == '0) ? '0 : DW'(1);
      end else begin
        cnt_q <= cnt_q - DW'(1);
      end
    end
  end

  assign cnt_o = cnt_q;
  assign pwm_o = en_i && (duty_i != '0) && ((duty_i >= period_i) || (cnt_q < duty_i));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_chan_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              special_mode_i,
  input  logic              debug_halt_i,
  output logic              pwm_o
);
  logic          en, center, scale_wr, cnt_wr, tick, run;
  logic [DW-1:0] scale, period, duty, cnt;
  test_bits_t    test;

  pwm_chan_regs #(.DW(DW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .special_mode_i,
    .cnt_i(cnt), .rdata_o,
    .en_o(en), .center_o(center), .scale_o(scale), .period_o(period),
    .duty_o(duty), .test_o(test), .scale_wr_o(scale_wr), .cnt_wr_o(cnt_wr)
  );

  assign run = !(test.halt_dbg && debug_halt_i);

  pwm_chan_scaler #(.DW(DW)) u_scaler (
    .clk_i, .rst_ni, .run_i(run), .load_i(scale_wr), .load_val_i(wdata_i),
    .scale_i(scale), .tick_o(tick)
  );

  pwm_chan_counter #(.DW(DW)) u_counter (
    .clk_i, .rst_ni, .en_i(en), .center_i(center), .tick_i(tick),
    .clr_i(cnt_wr && !test.keep_cnt), .ign_period_i(test.ign_period),
    .period_i(period), .duty_i(duty), .cnt_o(cnt), .pwm_o
  );
endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          special_mode_i,
  input logic          debug_halt_i,
  input logic          pwm_o,
  input logic          en,
  input logic          cnt_wr,
  input logic [DW-1:0] duty,
  input logic [DW-1:0] cnt,
  input logic [3:0]    test_bits
);
  // R13
  disabled_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !pwm_o);

  // R5
  zero_duty_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty == '0) |-> !pwm_o);

  // R12
  test_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !special_mode_i |=> (test_bits == 4'b0));

  // R6
  cnt_wr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_wr && !test_bits[0]) |=> (cnt == '0));

  // R11
  debug_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_bits[3] && debug_halt_i && en && !cnt_wr) |=> (cnt == $past(cnt)) || !en);
endmodule

bind pwm_chan pwm_chan_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .special_mode_i(special_mode_i),
  .debug_halt_i(debug_halt_i), .pwm_o(pwm_o), .en(en), .cnt_wr(cnt_wr),
  .duty(duty), .cnt(cnt), .test_bits(test)
);

// File: tb/pwm_chan_test.sv
`timescale 1ns/1ps
module pwm_chan_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       special_mode_i = 1'b0;
  logic       debug_halt_i = 1'b0;
  logic       pwm_o;

  int checks = 0;
  int fails = 0;

  always #2.5 clk_i = ~clk_i;

  pwm_chan uut (.*);

  typedef struct packed {
    logic [7:0]  period;
    logic [7:0]  duty;
    logic        center;
    logic [7:0]  scale;
    logic [15:0] highs;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'd10, 8'd3,  1'b0, 8'd0, 16'd3},
    '{8'd10, 8'd0,  1'b0, 8'd0, 16'd0},
    '{8'd10, 8'd10, 1'b0, 8'd0, 16'd10},
    '{8'd10, 8'd15, 1'b0, 8'd1, 16'd20},
    '{8'd8,  8'd1,  1'b0, 8'd2, 16'd3},
    '{8'd6,  8'd2,  1'b1, 8'd0, 16'd3},
    '{8'd6,  8'd6,  1'b1, 8'd0, 16'd12},
    '{8'd6,  8'd0,  1'b1, 8'd1, 16'd0},
    '{8'd5,  8'd4,  1'b1, 8'd0, 16'd7},
    '{8'd12, 8'd7,  1'b1, 8'd2, 16'd39}
  };

  task automatic finish_sim();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    addr_i = a;
    #0.5;
    v = int'(rdata_o);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // read count at this negedge, then write at the next edge
  task automatic rd_cnt_then_wr(input logic [2:0] a, input logic [7:0] d, output int c);
    @(negedge clk_i);
    rd(3'd4, c);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic restart(input logic [7:0] ctrl);
    wr(3'd0, 8'd0);
    wr(3'd0, ctrl);
  endtask

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    int v, c0, c1, hi, win;
    string tag;
    cycles(3);
    rst_ni = 1'b1;
    cycles(2);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R1 reg", v, 0);
    end
    check("R1 pwm", int'(pwm_o), 0);

    // vector table: one full cycle window of highs
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, 8'd0);
      wr(3'd1, VECS[i].scale);
      wr(3'd2, VECS[i].period);
      wr(3'd3, VECS[i].duty);
      wr(3'd0, {6'd0, VECS[i].center, 1'b1});
      cycles(7);
      win = (VECS[i].center ? 2 * int'(VECS[i].period) : int'(VECS[i].period))
            * (int'(VECS[i].scale) + 1);
      hi = 0;
      for (int k = 0; k < win; k++) begin
        @(negedge clk_i);
        hi += int'(pwm_o);
      end
      if (VECS[i].duty == 0 || VECS[i].duty >= VECS[i].period) tag = "R5 vector";
      else if (VECS[i].scale != 0) tag = "R2 vector";
      else if (VECS[i].center) tag = "R4 vector";
      else tag = "R3 vector";
      check(tag, hi, int'(VECS[i].highs));
    end

    // R13 disabled channel
    wr(3'd3, 8'd200);
    wr(3'd0, 8'd0);
    cycles(3);
    check("R13 pwm", int'(pwm_o), 0);
    rd(3'd4, v);
    check("R13 count", v, 0);

    // R3 edge mode restart after period-1
    wr(3'd1, 8'd0);
    wr(3'd3, 8'd0);
    wr(3'd2, 8'd5);
    restart(8'd1);
    cycles(7);
    rd(3'd4, v);
    check("R3 wrap", v, 2);

    // R12 test register access
    wr(3'd5, 8'h0F);
    rd(3'd5, v);
    check("R12 normal write", v, 0);
    special_mode_i = 1'b1;
    wr(3'd5, 8'h05);
    rd(3'd5, v);
    check("R12 special write", v, 5);
    special_mode_i = 1'b0;
    cycles(1);
    rd(3'd5, v);
    check("R12 forced clear", v, 0);
    special_mode_i = 1'b1;

    // R6 / R7 count write
    wr(3'd5, 8'h00);
    wr(3'd2, 8'd250);
    restart(8'd1);
    cycles(20);
    rd_cnt_then_wr(3'd4, 8'd99, c0);
    rd(3'd4, c1);
    check("R6 count clear", c1, 0);
    wr(3'd5, 8'h01);
    cycles(10);
    rd_cnt_then_wr(3'd4, 8'd99, c0);
    rd(3'd4, c1);
    check("R7 count kept", c1, c0 + 1);

    // R8 edge mode, period ignored
    wr(3'd5, 8'h02);
    wr(3'd2, 8'd5);
    restart(8'd1);
    cycles(20);
    rd(3'd4, v);
    check("R8 no restart", v, 20);
    wr(3'd5, 8'h00);
    restart(8'd1);
    cycles(20);
    rd(3'd4, v);
    check("R8 control restart", v, 0);

    // R9 center mode, period ignored
    wr(3'd2, 8'd3);
    restart(8'd3);
    cycles(10);
    rd(3'd4, v);
    check("R4 center count", v, 2);
    wr(3'd5, 8'h02);
    restart(8'd3);
    cycles(10);
    rd(3'd4, v);
    check("R9 no reversal", v, 10);

    // R10 / R2 scale load
    wr(3'd5, 8'h00);
    wr(3'd2, 8'd250);
    restart(8'd1);
    cycles(5);
    rd_cnt_then_wr(3'd1, 8'd200, c0);
    cycles(4);
    rd(3'd4, c1);
    check("R2 scale load", c1, c0 + 1);
    wr(3'd1, 8'd0);
    wr(3'd5, 8'h04);
    restart(8'd1);
    cycles(5);
    rd_cnt_then_wr(3'd1, 8'd200, c0);
    cycles(4);
    rd(3'd4, c1);
    check("R10 no scale load", c1, c0 + 2);
    wr(3'd5, 8'h00);
    wr(3'd1, 8'd0);

    // R11 debug halt
    restart(8'd1);
    debug_halt_i = 1'b1;
    wr(3'd5, 8'h08);
    rd(3'd4, c0);
    cycles(10);
    rd(3'd4, c1);
    check("R11 frozen", c1, c0);
    wr(3'd5, 8'h00);
    restart(8'd1);
    rd(3'd4, c0);
    cycles(10);
    rd(3'd4, c1);
    check("R11 runs when bit clear", c1, c0 + 10);
    debug_halt_i = 1'b0;

    finish_sim();
  end
endmodule